// File: doc/BRIEF.md
# Quasi-Resonant Turn-On Trigger Controller

This block decides the cycle in which a flyback power switch is turned on. It watches two digitised comparators on the transformer demagnetisation sense node: one says the node is above an arming level, the other says it is above a lower triggering level. The trigger is armed only by a rising crossing of the arming level, and only then does the following falling crossing of the triggering level request turn-on. Timing is measured from the switch's own turn-off: after the gate drops, a blanking window runs whose length follows a 4-bit code of the error-amplifier control level. Falling edges inside the window are skipped, so ringing valleys are passed over as the load drops. The switching rate is then bounded by both the window and a fixed minimum period.

When no usable demagnetisation edge arrives, as at power-up or when the output is too low to arm the trigger, a starter oscillator forces turn-on itself. It runs at a slow rate while the control level is under the burst threshold and at a fast rate above it. The output is a single-cycle set request for the gate latch, which lies outside this block. All control pins are plain levels. There is no streaming data path, so no valid/ready handshake applies. The three comparator and gate inputs pass through a synchroniser of `SYNC_STAGES` flops, and all three see the same delay.

Top module: `qr_trigger_ctrl`

## Requirements
- R1: A request caused by a demagnetisation edge needs a prior rising edge of `arm_cmp_i` seen while the gate is low, followed by a falling edge of `trig_cmp_i`. A falling edge of `trig_cmp_i` with no arming produces no request. A rising `arm_cmp_i` while `gate_i` is high arms nothing.
- R2: The armed state is cleared while `gate_i` is high and by every request. A falling edge with no fresh arming after either event produces no request.
- R3: Let B be the blanking length. A falling edge of `trig_cmp_i` that comes d cycles after the falling edge of `gate_i`, with both counted at the ports, is skipped when d < B. It produces a request when d >= B. The first armed falling edge after the window requests turn-on.
- R4: B in clock cycles is `BLANK_MAX` for `ctrl_code_i <= CODE_LO` and `BLANK_MIN` for `ctrl_code_i >= CODE_HI`. Between these limits it is `BLANK_MAX - ((BLANK_MAX-BLANK_MIN)/(CODE_HI-CODE_LO))*(ctrl_code_i-CODE_LO)`.
- R5: Two requests are never closer than `MIN_PERIOD` cycles. An armed edge that arrives sooner is dropped.
- R6: If no request occurs for `START_FAST` cycles while `burst_i` is low, a request is forced. With `burst_i` high the interval is `START_SLOW` cycles instead. Forced requests repeat at exactly that spacing. After reset the first one comes `START_FAST` cycles after release when `burst_i` is low.
- R7: The starter interval restarts on every request, including edge-caused ones.
- R8: `turn_on_o` is low in reset and is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_cmp_i | input | 1 | High while the sense node is above the arming level |
| trig_cmp_i | input | 1 | High while the sense node is above the triggering level |
| gate_i | input | 1 | Switch gate state, high while on |
| ctrl_code_i | input | CODE_W | Control-level code that selects the blanking length |
| burst_i | input | 1 | High while the control level is below the burst threshold (slow starter) |
| turn_on_o | output | 1 | One-cycle turn-on request to the gate latch |

## Verification
The hardest case to reach is an armed falling edge that lands exactly one cycle before or on the last cycle of the blanking window, for every code region. The starter must stay quiet and the minimum period must not mask the result. The bench drives the gate low, arms, and then places the falling edge at d = B-1 and d = B, with B computed from R4, for codes below, inside and above the linear range. It keeps every vector well inside one starter interval and beyond the minimum period. A skipped edge is followed by a late armed edge that must fire. A fire is followed by an unarmed edge that must not fire. Each is spaced far enough apart that only arming can explain the outcome.

// File: rtl/qr_trig_pkg.sv
package qr_trig_pkg;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_ARMED = 1'b1
  } arm_state_e;

  typedef struct packed {
    logic arm;
    logic trig;
    logic gate;
  } sense_t;

endpackage

// File: rtl/qr_sync.sv
module qr_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '0;
    end else begin
      pipe[0] <= d_i;
      for (int s = 1; s < STAGES; s++) begin
        pipe[s] <= pipe[s-1];
      end
    end
  end

  assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/qr_blank_timer.sv
module qr_blank_timer #(
  parameter int CODE_W    = 4,
  parameter int CODE_LO   = 3,
  parameter int CODE_HI   = 11,
  parameter int BLANK_MAX = 3750,
  parameter int BLANK_MIN = 750
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_s_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              blank_ok_o
);

  localparam int BW   = $clog2(BLANK_MAX + 1);
  localparam int SPAN = CODE_HI - CODE_LO;
  localparam int STEP = (BLANK_MAX - BLANK_MIN) / SPAN;

  logic [BW-1:0] blank_len;
  logic [BW-1:0] cnt;

  // control-level code to window length, clamped at both ends
  always_comb begin
    if (int'(code_i) <= CODE_LO) begin
      blank_len = BW'(BLANK_MAX);
    end else if (int'(code_i) >= CODE_HI) begin
      blank_len = BW'(BLANK_MIN);
    end else begin
      blank_len = BW'(BLANK_MAX - STEP * (int'(code_i) - CODE_LO));
    end
  end

  // reloaded while the switch conducts, counts down once it is off
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (gate_s_i) begin
      cnt <= blank_len;
    end else if (cnt != '0) begin
      cnt <= cnt - BW'(1);
    end
  end

  assign blank_ok_o = (cnt == '0);

  p_len_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_len >= BW'(BLANK_MIN)) && (blank_len <= BW'(BLANK_MAX)));

  p_open_stays_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_ok_o && !gate_s_i) |=> blank_ok_o);

  p_conduct_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gate_s_i |=> !blank_ok_o);

endmodule

// File: rtl/qr_edge_fsm.sv
module qr_edge_fsm
  import qr_trig_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm_s_i,
  input  logic trig_s_i,
  input  logic gate_s_i,
  input  logic blank_ok_i,
  input  logic period_ok_i,
  input  logic fire_i,
  output logic edge_fire_o
);

  arm_state_e state;
  logic       arm_d;
  logic       trig_d;
  logic       arm_rise;
  logic       trig_fall;

  assign arm_rise  = arm_s_i & ~arm_d;
  assign trig_fall = trig_d & ~trig_s_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_d  <= 1'b0;
      trig_d <= 1'b0;
      state  <= ST_IDLE;
    end else begin
      arm_d  <= arm_s_i;
      trig_d <= trig_s_i;
      if (gate_s_i || fire_i) begin
        state <= ST_IDLE;
      end else if (arm_rise) begin
        state <= ST_ARMED;
      end
    end
  end

  assign edge_fire_o = (state == ST_ARMED) & trig_fall & blank_ok_i
                     & period_ok_i & ~gate_s_i;

  p_gate_disarms_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gate_s_i |=> (state == ST_IDLE));

  p_fire_disarms_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> (state == ST_IDLE));

endmodule

// File: rtl/qr_starter.sv
module qr_starter #(
  parameter int START_SLOW = 62500,
  parameter int START_FAST = 15625
) (
  input  logic clk,
  input  logic rst_n,
  input  logic burst_i,
  input  logic restart_i,
  output logic start_fire_o
);

  localparam int SW = $clog2(START_SLOW + 1);

  logic [SW-1:0] scnt;
  logic [SW-1:0] limit;

  assign limit        = burst_i ? SW'(START_SLOW - 1) : SW'(START_FAST - 1);
  assign start_fire_o = (scnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt <= '0;
    end else if (restart_i) begin
      scnt <= '0;
    end else begin
      scnt <= scnt + SW'(1);
    end
  end

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    scnt <= SW'(START_SLOW - 1));

endmodule

// File: rtl/qr_trigger_ctrl.sv
module qr_trigger_ctrl
  import qr_trig_pkg::*;
#(
  parameter int CODE_W      = 4,
  parameter int CODE_LO     = 3,
  parameter int CODE_HI     = 11,
  parameter int BLANK_MAX   = 3750,
  parameter int BLANK_MIN   = 750,
  parameter int MIN_PERIOD  = 753,
  parameter int START_SLOW  = 62500,
  parameter int START_FAST  = 15625,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_cmp_i,
  input  logic              trig_cmp_i,
  input  logic              gate_i,
  input  logic [CODE_W-1:0] ctrl_code_i,
  input  logic              burst_i,
  output logic              turn_on_o
);

  localparam int PW = $clog2(MIN_PERIOD + 1);

  sense_t        raw;
  sense_t        syn;
  logic          blank_ok;
  logic          period_ok;
  logic          edge_fire;
  logic          start_fire;
  logic          fire;
  logic [PW-1:0] pcnt;

  assign raw = '{arm: arm_cmp_i, trig: trig_cmp_i, gate: gate_i};

  qr_sync #(
    .W      ($bits(sense_t)),
    .STAGES (SYNC_STAGES)
  ) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw),
    .q_o   (syn)
  );

  qr_blank_timer #(
    .CODE_W    (CODE_W),
    .CODE_LO   (CODE_LO),
    .CODE_HI   (CODE_HI),
    .BLANK_MAX (BLANK_MAX),
    .BLANK_MIN (BLANK_MIN)
  ) blank_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate_s_i   (syn.gate),
    .code_i     (ctrl_code_i),
    .blank_ok_o (blank_ok)
  );

  qr_edge_fsm edge_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm_s_i     (syn.arm),
    .trig_s_i    (syn.trig),
    .gate_s_i    (syn.gate),
    .blank_ok_i  (blank_ok),
    .period_ok_i (period_ok),
    .fire_i      (fire),
    .edge_fire_o (edge_fire)
  );

  qr_starter #(
    .START_SLOW (START_SLOW),
    .START_FAST (START_FAST)
  ) start_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .burst_i      (burst_i),
    .restart_i    (fire),
    .start_fire_o (start_fire)
  );

  assign fire = edge_fire | start_fire;

  // frequency ceiling: hold-off counted from each request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
    end else if (fire) begin
      pcnt <= PW'(MIN_PERIOD - 1);
    end else if (pcnt != '0) begin
      pcnt <= pcnt - PW'(1);
    end
  end

  assign period_ok = (pcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      turn_on_o <= 1'b0;
    end else begin
      turn_on_o <= fire;
    end
  end

  // spacing observer for the ceiling check
  logic [PW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= PW'(MIN_PERIOD);
    end else if (turn_on_o) begin
      gap_q <= PW'(1);
    end else if (gap_q != PW'(MIN_PERIOD)) begin
      gap_q <= gap_q + PW'(1);
    end
  end

  p_min_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    turn_on_o |-> (gap_q >= PW'(MIN_PERIOD)));

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    turn_on_o |=> !turn_on_o);

  p_starter_restarted_r7: assert property (@(posedge clk) disable iff (!rst_n)
    turn_on_o |-> !start_fire);

endmodule

// File: tb/qr_trigger_ctrl_tb_top.sv
`timescale 1ns/1ps
module qr_trigger_ctrl_tb_top;

  localparam int CODE_W     = 4;
  localparam int CODE_LO    = 3;
  localparam int CODE_HI    = 11;
  localparam int BMAX       = 300;
  localparam int BMIN       = 60;
  localparam int MIN_PER    = 80;
  localparam int SLOW       = 4000;
  localparam int FAST       = 1000;

  // {code, offset from B, expected request count}
  localparam int NV = 16;
  localparam int VEC [NV][3] = '{
    '{0, -1, 0}, '{0, 0, 1}, '{3, -1, 0}, '{3, 0, 1},
    '{5, -1, 0}, '{5, 0, 1}, '{7, -1, 0}, '{7, 0, 1},
    '{9, -1, 0}, '{9, 0, 1}, '{11, -1, 0}, '{11, 0, 1},
    '{13, -1, 0}, '{13, 0, 1}, '{15, -1, 0}, '{15, 0, 1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0;
  logic trig = 1'b1;
  logic gate = 1'b0;
  logic [CODE_W-1:0] code = '0;
  logic burst = 1'b0;
  logic turn_on;

  always #4 clk = ~clk;

  qr_trigger_ctrl #(
    .CODE_W (CODE_W), .CODE_LO (CODE_LO), .CODE_HI (CODE_HI),
    .BLANK_MAX (BMAX), .BLANK_MIN (BMIN), .MIN_PERIOD (MIN_PER),
    .START_SLOW (SLOW), .START_FAST (FAST), .SYNC_STAGES (2)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .arm_cmp_i (arm), .trig_cmp_i (trig),
    .gate_i (gate), .ctrl_code_i (code), .burst_i (burst), .turn_on_o (turn_on)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc = 0;
  int req_cnt = 0;
  int last_req = 0;
  int dbl = 0;
  logic prev_req = 1'b0;
  bit done = 0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (turn_on === 1'b1) begin
      req_cnt = req_cnt + 1;
      last_req = cyc;
      if (prev_req) dbl = dbl + 1;
    end
    prev_req = turn_on;
  end

  task automatic wait_neg(input int k);
    repeat (k) @(negedge clk);
    #1;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_blank(input int c);
    if (c <= CODE_LO) return BMAX;
    if (c >= CODE_HI) return BMIN;
    return BMAX - ((BMAX - BMIN) / (CODE_HI - CODE_LO)) * (c - CODE_LO);
  endfunction

  // turn-off at N, arm at N+2, trigger falls at N+d
  task automatic run_edge(input int c, input int d, output int got);
    int c0;
    code = CODE_W'(c);
    trig = 1'b1;
    gate = 1'b1;
    wait_neg(20);
    c0 = req_cnt;
    gate = 1'b0;
    wait_neg(2);
    arm = 1'b1;
    wait_neg(1);
    arm = 1'b0;
    wait_neg(d - 3);
    trig = 1'b0;
    wait_neg(8);
    got = req_cnt - c0;
  endtask

  task automatic ring(input bit armed, output int got);
    int c0;
    trig = 1'b1;
    wait_neg(2);
    c0 = req_cnt;
    if (armed) begin
      arm = 1'b1;
      wait_neg(1);
      arm = 1'b0;
    end
    wait_neg(100);
    trig = 1'b0;
    wait_neg(8);
    got = req_cnt - c0;
  endtask

  task automatic wait_req(output int t);
    int c0;
    int k;
    c0 = req_cnt;
    k = 0;
    while (req_cnt == c0 && k < 20000) begin
      wait_neg(1);
      k++;
    end
    t = last_req;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int got;
    int t1, t2, t3;
    wait_neg(5);
    check("R8 low in reset", int'(turn_on), 0);
    rst_n = 1'b1;
    wait_neg(900);
    check("R6 no early starter after reset", req_cnt, 0);
    wait_neg(200);
    check("R6 first starter after reset", req_cnt, 1);

    // vector walk across the blanking boundary, R3 and R4
    for (int i = 0; i < NV; i++) begin
      int b;
      int d;
      b = exp_blank(VEC[i][0]);
      d = b + VEC[i][1];
      wait_neg(30);
      run_edge(VEC[i][0], d, got);
      check($sformatf("R3/R4 code=%0d d=%0d", VEC[i][0], d), got, VEC[i][2]);
      if (VEC[i][2] == 0) begin
        ring(1'b1, got);
        check($sformatf("R3 first edge after window code=%0d", VEC[i][0]), got, 1);
      end
      ring(1'b0, got);
      check($sformatf("R2 request clears arm code=%0d", VEC[i][0]), got, 0);
    end

    // R5 ceiling: armed edge soon after a request is dropped
    wait_neg(30);
    run_edge(15, 60, got);
    check("R5 setup fire", got, 1);
    trig = 1'b1;
    gate = 1'b1;
    wait_neg(4);
    t1 = req_cnt;
    gate = 1'b0;
    wait_neg(2);
    arm = 1'b1;
    wait_neg(1);
    arm = 1'b0;
    wait_neg(59);
    trig = 1'b0;
    wait_neg(8);
    check("R5 edge inside minimum period", req_cnt - t1, 0);
    ring(1'b1, got);
    check("R5 edge after minimum period", got, 1);

    // R7 and R6 starter spacing
    t1 = last_req;
    wait_req(t2);
    check("R7 starter restarted by edge request", t2 - t1, FAST);
    wait_req(t3);
    check("R6 fast starter spacing", t3 - t2, FAST);
    burst = 1'b1;
    wait_req(t2);
    wait_req(t3);
    check("R6 slow starter spacing", t3 - t2, SLOW);
    burst = 1'b0;

    // R1 falling edge with no arming
    trig = 1'b1;
    code = CODE_W'(15);
    gate = 1'b1;
    wait_neg(20);
    t1 = req_cnt;
    gate = 1'b0;
    wait_neg(100);
    trig = 1'b0;
    wait_neg(8);
    check("R1 unarmed edge ignored", req_cnt - t1, 0);

    // R2 gate high clears arming
    trig = 1'b1;
    wait_neg(2);
    t1 = req_cnt;
    arm = 1'b1;
    wait_neg(1);
    arm = 1'b0;
    wait_neg(10);
    gate = 1'b1;
    wait_neg(5);
    gate = 1'b0;
    wait_neg(100);
    trig = 1'b0;
    wait_neg(8);
    check("R2 gate high clears arm", req_cnt - t1, 0);

    // R1 arming while gate high does nothing
    trig = 1'b1;
    gate = 1'b1;
    wait_neg(5);
    t1 = req_cnt;
    arm = 1'b1;
    wait_neg(1);
    arm = 1'b0;
    wait_neg(5);
    gate = 1'b0;
    wait_neg(100);
    trig = 1'b0;
    wait_neg(8);
    check("R1 arm during conduction ignored", req_cnt - t1, 0);

    ring(1'b1, got);
    check("R1 armed edge fires", got, 1);

    check("R8 no back-to-back pulses", dbl, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule